// File: doc/BRIEF.md
# Trapezoid Edge Waveform Synthesizer

This block drives a fast DAC with a repeating trapezoid: it climbs a sixteen-sample staircase, rests on a high plateau, descends a sixteen-sample staircase, rests on a low plateau, and climbs again. An external smoothing filter and comparator turn this into a square wave. The edge timing of that square wave can be set to 1/1024 of a sample period. Each staircase is one of 1024 variants. Variant k raises (rising edge) or lowers (falling edge) every step by k/1024 of one step height, which moves the filtered crossing earlier by k/1024 of a sample.

The period arrives as an unsigned word in units of 1/1024 sample. Each edge has an ideal start position on a sub-sample time line. The block starts the edge on the first whole sample at or after that position. It picks the variant that pulls the crossing back by the remaining fraction. The gap between edge starts sets the plateau length. A period word is taken only when a rising edge begins. Periods shorter than 32 samples are raised to 32.

States: IDLE (output held low), RISE, HIGH, FALL, LOW. The transitions are:
- IDLE to RISE when enabled.
- RISE to HIGH, or straight to FALL when the high plateau is zero samples long.
- HIGH to FALL when the plateau count runs out.
- FALL to LOW, or straight to RISE when the low plateau is zero samples long.
- LOW to RISE when the count runs out.
- Any state to IDLE when enable is low.

Top module: `trap_edge_synth`

## Requirements
- R1: The segments repeat in the order rising edge, high plateau (level HI_CODE=15871), falling edge, low plateau (level LO_CODE=512). A plateau may be zero samples long.
- R2: Every edge lasts exactly 16 consecutive samples. Rising edges never decrease and falling edges never increase.
- R3: Step i (0..15) of variant k is LO_CODE+v on a rising edge and HI_CODE−v on a falling edge. Here v = floor(((i·1024+k)·(HI_CODE−LO_CODE) + 8192) / 16384), limited to HI_CODE−LO_CODE. The output never leaves [LO_CODE, HI_CODE].
- R4: Let edge n have ideal position A_n (in 1/1024 sample). It starts at sample ceil(A_n/1024), counted from the first rising edge sample. It uses variant k = 1024·ceil(A_n/1024) − A_n.
- R5: With latched period P, the falling edge has A = A_rise + floor(P/2). The next rising edge has A = A_rise + P.
- R6: The period input is sampled only on the clock edge that starts a rising edge. Changes at other times take effect only at the next rising edge.
- R7: While reset is asserted, the output is LO_CODE. Starting one clock after enable is seen low, the output is LO_CODE and the sub-sample position is cleared. The first sample after enable returns is rising step 0 of variant 0.
- R8: A period word below 32768 behaves as 32768.
- R9: At period 32768 the edges abut with no plateau samples, giving 32 samples per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| enable_i | input | 1 | Run when high; hold low level when low |
| period_i | input | 32 | Period in 1/1024 sample units |
| dac_code_o | output | 14 | DAC sample code |

## Verification
The output is a function of the state, step, variant and plateau registers. A wrong internal value shows at the ports within one sample:
- A wrong variant shifts every step of the edge in progress.
- A wrong plateau count moves the next edge start, and every later edge, by whole samples.
- A slipped accumulator fraction builds up as wrong variants and edge starts over the following cycles.
- A period latched at the wrong time changes the falling edge position in the same cycle.

The bench compares every sample against an absolute-time model. The model computes each edge position from the sum of the periods since enable, not from an incremental gap, so accumulated drift is caught.

// File: rtl/trap_synth_pkg.sv
package trap_synth_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RISE = 3'd1,
        ST_HIGH = 3'd2,
        ST_FALL = 3'd3,
        ST_LOW  = 3'd4
    } trap_state_e;

endpackage

// File: rtl/trap_edge_gap.sv
// Given the half-period (1/2^FRAC_W sample units) and the variant of the
// edge in progress, returns the plateau length before the next edge and
// the variant the next edge needs.
module trap_edge_gap #(
    parameter int PER_W  = 32,
    parameter int FRAC_W = 10,
    parameter int STEPS  = 16,
    localparam int SUM_W  = PER_W + 1,
    localparam int PLAT_W = SUM_W - FRAC_W
) (
    input  logic [PER_W-1:0]  half_i,
    input  logic [FRAC_W-1:0] var_i,
    output logic [PLAT_W-1:0] plat_o,
    output logic [FRAC_W-1:0] var_next_o
);
    localparam logic [SUM_W-1:0] FRAC_MAX = SUM_W'((1 << FRAC_W) - 1);

    logic [SUM_W-1:0]  sum;
    logic [PLAT_W-1:0] gap;

    always_comb begin
        // ceil((half - var) / 2^FRAC_W) sits in the upper bits of sum
        sum        = {1'b0, half_i} - SUM_W'(var_i) + FRAC_MAX;
        gap        = sum[SUM_W-1:FRAC_W];
        plat_o     = gap - PLAT_W'(STEPS);
        var_next_o = ~sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/trap_stair_level.sv
// Staircase level of step step_i for variant var_i, in both directions.
module trap_stair_level #(
    parameter int CODE_W  = 14,
    parameter int STEP_W  = 4,
    parameter int FRAC_W  = 10,
    parameter int LO_CODE = 512,
    parameter int HI_CODE = 15871,
    localparam int IDX_W  = STEP_W + FRAC_W,
    localparam int PROD_W = IDX_W + CODE_W + 1
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [FRAC_W-1:0] var_i,
    output logic [CODE_W-1:0] rise_code_o,
    output logic [CODE_W-1:0] fall_code_o
);
    localparam int SPAN = HI_CODE - LO_CODE;
    localparam logic [PROD_W-1:0] SPAN_P = PROD_W'(SPAN);
    localparam logic [PROD_W-1:0] HALF_P = PROD_W'(1) << (IDX_W - 1);
    localparam logic [CODE_W-1:0] SPAN_C = CODE_W'(SPAN);
    localparam logic [CODE_W-1:0] LO_C   = CODE_W'(LO_CODE);
    localparam logic [CODE_W-1:0] HI_C   = CODE_W'(HI_CODE);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [CODE_W-1:0] offs;

    always_comb begin
        prod   = PROD_W'({step_i, var_i}) * SPAN_P + HALF_P;
        scaled = prod >> IDX_W;
        offs   = (scaled > PROD_W'(SPAN)) ? SPAN_C : scaled[CODE_W-1:0];
        rise_code_o = LO_C + offs;
        fall_code_o = HI_C - offs;
    end

endmodule

// File: rtl/trap_edge_synth.sv
module trap_edge_synth
    import trap_synth_pkg::*;
#(
    parameter int CODE_W  = 14,
    parameter int PER_W   = 32,
    parameter int FRAC_W  = 10,
    parameter int STEP_W  = 4,
    parameter int LO_CODE = 512,
    parameter int HI_CODE = 15871
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              enable_i,
    input  logic [PER_W-1:0]  period_i,
    output logic [CODE_W-1:0] dac_code_o
);
    localparam int STEPS  = 1 << STEP_W;
    localparam int PLAT_W = PER_W + 1 - FRAC_W;
    localparam logic [PER_W-1:0]  MIN_PER = PER_W'((2 * STEPS) << FRAC_W);
    localparam logic [STEP_W-1:0] LAST    = STEP_W'(STEPS - 1);

    trap_state_e       st_q, st_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [PLAT_W-1:0] plat_q, plat_d;
    logic [FRAC_W-1:0] var_q, var_d;
    logic [PER_W-1:0]  per_q, per_d;

    logic [PER_W-1:0]  per_clamped;
    logic [PER_W-1:0]  half_sel;
    logic [PLAT_W-1:0] plat_len;
    logic [FRAC_W-1:0] var_nx;
    logic [CODE_W-1:0] rise_code;
    logic [CODE_W-1:0] fall_code;
    logic              enter_rise;

    assign per_clamped = (period_i < MIN_PER) ? MIN_PER : period_i;
    // first half after a rising edge, remainder after a falling edge
    assign half_sel = (st_q == ST_RISE) ? (per_q >> 1) : (per_q - (per_q >> 1));

    trap_edge_gap #(
        .PER_W (PER_W),
        .FRAC_W(FRAC_W),
        .STEPS (STEPS)
    ) u_gap (
        .half_i    (half_sel),
        .var_i     (var_q),
        .plat_o    (plat_len),
        .var_next_o(var_nx)
    );

    trap_stair_level #(
        .CODE_W (CODE_W),
        .STEP_W (STEP_W),
        .FRAC_W (FRAC_W),
        .LO_CODE(LO_CODE),
        .HI_CODE(HI_CODE)
    ) u_level (
        .step_i     (step_q),
        .var_i      (var_q),
        .rise_code_o(rise_code),
        .fall_code_o(fall_code)
    );

    // next-state logic
    always_comb begin
        st_d       = st_q;
        step_d     = step_q;
        plat_d     = plat_q;
        var_d      = var_q;
        per_d      = per_q;
        enter_rise = 1'b0;
        if (!enable_i) begin
            st_d   = ST_IDLE;
            step_d = '0;
            plat_d = '0;
            var_d  = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: enter_rise = 1'b1;
                ST_RISE, ST_FALL: begin
                    if (step_q == LAST) begin
                        var_d = var_nx;
                        if (plat_len == '0) begin
                            if (st_q == ST_RISE) begin
                                st_d   = ST_FALL;
                                step_d = '0;
                            end else begin
                                enter_rise = 1'b1;
                            end
                        end else begin
                            st_d   = (st_q == ST_RISE) ? ST_HIGH : ST_LOW;
                            plat_d = plat_len - PLAT_W'(1);
                        end
                    end else begin
                        step_d = step_q + STEP_W'(1);
                    end
                end
                ST_HIGH, ST_LOW: begin
                    if (plat_q == '0) begin
                        if (st_q == ST_HIGH) begin
                            st_d   = ST_FALL;
                            step_d = '0;
                        end else begin
                            enter_rise = 1'b1;
                        end
                    end else begin
                        plat_d = plat_q - PLAT_W'(1);
                    end
                end
                default: st_d = ST_IDLE;
            endcase
            if (enter_rise) begin
                st_d   = ST_RISE;
                step_d = '0;
                per_d  = per_clamped;
            end
        end
    end

    // state register
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            plat_q <= '0;
            var_q  <= '0;
            per_q  <= MIN_PER;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
            plat_q <= plat_d;
            var_q  <= var_d;
            per_q  <= per_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_RISE: dac_code_o = rise_code;
            ST_FALL: dac_code_o = fall_code;
            ST_HIGH: dac_code_o = CODE_W'(HI_CODE);
            default: dac_code_o = CODE_W'(LO_CODE);
        endcase
    end

endmodule

// File: rtl/trap_synth_chk.sv
module trap_synth_chk
    import trap_synth_pkg::*;
#(
    parameter int CODE_W  = 14,
    parameter int PER_W   = 32,
    parameter int STEP_W  = 4,
    parameter int FRAC_W  = 10,
    parameter int LO_CODE = 512,
    parameter int HI_CODE = 15871
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              enable_i,
    input trap_state_e       st_q,
    input logic [STEP_W-1:0] step_q,
    input logic [PER_W-1:0]  per_q,
    input logic [CODE_W-1:0] dac_code_o
);
    localparam logic [PER_W-1:0] MIN_PER = PER_W'((2 << STEP_W) << FRAC_W);

    assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> (dac_code_o == CODE_W'(LO_CODE)));

    assert_rise_monotonic_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RISE && step_q != '0) |-> (dac_code_o >= $past(dac_code_o)));

    assert_fall_monotonic_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_FALL && step_q != '0) |-> (dac_code_o <= $past(dac_code_o)));

    assert_step_advance_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q == ST_RISE || st_q == ST_FALL) && step_q != '0)
        |-> (step_q == $past(step_q) + STEP_W'(1)));

    assert_fall_entry_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_FALL && $past(st_q) != ST_FALL)
        |-> ($past(st_q) == ST_HIGH || $past(st_q) == ST_RISE));

    assert_period_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q != ST_RISE || step_q != '0) |-> $stable(per_q));

    assert_min_period_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_RISE) |-> (per_q >= MIN_PER));

    assert_code_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (dac_code_o >= CODE_W'(LO_CODE)) && (dac_code_o <= CODE_W'(HI_CODE)));

endmodule

bind trap_edge_synth trap_synth_chk #(
    .CODE_W (CODE_W),
    .PER_W  (PER_W),
    .STEP_W (STEP_W),
    .FRAC_W (FRAC_W),
    .LO_CODE(LO_CODE),
    .HI_CODE(HI_CODE)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .enable_i  (enable_i),
    .st_q      (st_q),
    .step_q    (step_q),
    .per_q     (per_q),
    .dac_code_o(dac_code_o)
);

// File: tb/test_trap_edge_synth.sv
`timescale 1ns/1ps
module test_trap_edge_synth;
    localparam int  LO   = 512;
    localparam int  HI   = 15871;
    localparam int  SPAN = HI - LO;
    localparam int  NCYC = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] period = 32'd32768;
    logic [13:0] dac_code;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // model state
    bit     act = 1'b0;
    longint r_s, r_k, f_s, f_k, nr_s, nr_k;
    bit     rst_p = 1'b1, en_p = 1'b0;
    longint per_p = 32768;

    always #2 clk = ~clk;

    trap_edge_synth i_trap_edge_synth (
        .clk_i     (clk),
        .rst_i     (rst),
        .enable_i  (en),
        .period_i  (period),
        .dac_code_o(dac_code)
    );

    function automatic longint lvl(longint i, longint k, bit rising);
        longint v;
        v = ((i * 1024 + k) * SPAN + 8192) >>> 14;
        if (v > SPAN) v = SPAN;
        return rising ? (LO + v) : (HI - v);
    endfunction

    function automatic longint ceil_s(longint a);
        return (a + 1023) >>> 10;
    endfunction

    // absolute-time schedule of one cycle starting with a rising edge
    task automatic start_rise(longint s, longint k, longint p);
        longint pc, ar, af, an;
        pc   = (p < 32768) ? 32768 : p;
        r_s  = s;
        r_k  = k;
        ar   = s * 1024 - k;
        af   = ar + (pc >>> 1);
        f_s  = ceil_s(af);
        f_k  = f_s * 1024 - af;
        an   = ar + pc;
        nr_s = ceil_s(an);
        nr_k = nr_s * 1024 - an;
    endtask

    task automatic chk(int t, string tag, longint exp);
        n_chk++;
        if (longint'(dac_code) != exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, dac_code, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20220814));
        for (int t = 0; t < NCYC; t++) begin
            longint exp;
            string  tag;
            @(negedge clk);
            // expected value for this sample
            if (rst_p || !en_p) begin
                act = 1'b0;
                exp = LO;
                tag = "R7";
            end else begin
                if (!act) begin
                    act = 1'b1;
                    start_rise(t, 0, per_p);
                end else if (t == nr_s) begin
                    start_rise(nr_s, nr_k, per_p);
                end
                if (t < r_s + 16) begin
                    exp = lvl(t - r_s, r_k, 1'b1);
                    tag = (t == r_s) ? "R4" : ((t == r_s + 15) ? "R2" : "R3");
                end else if (t < f_s) begin
                    exp = HI;
                    tag = (t >= 2000) ? "R6" : "R1";
                end else if (t < f_s + 16) begin
                    exp = lvl(t - f_s, f_k, 1'b0);
                    tag = "R5";
                end else begin
                    exp = LO;
                    tag = (t >= 2000) ? "R6" : "R1";
                end
                if (t >= 5 && t < 400)       tag = "R9";
                else if (t >= 400 && t < 800) tag = "R8";
            end
            chk(t, tag, exp);

            // inputs for the next sample
            if (t < 5) begin
                rst = 1'b1; en = 1'b0; period = 32'd32768;
            end else if (t < 400) begin
                rst = 1'b0; en = 1'b1; period = 32'd32768;
            end else if (t < 800) begin
                en = 1'b1; period = 32'd700;
            end else if (t < 812) begin
                en = 1'b0; period = 32'd32769;
            end else if (t < 2000) begin
                en = 1'b1; period = 32'd32769 + 32'd1023 * 32'd7;
            end else begin
                en = ((t % 2500) >= 3);
                if ($urandom % 150 == 0)
                    period = 32'd20000 + ($urandom % 32'd260000);
            end
            rst_p = rst;
            en_p  = en;
            per_p = longint'(period);
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule